// File: doc/BRIEF.md
# Receive Status Flag and Interrupt Unit

This unit keeps the error and event flags for the receive half of an asynchronous serial port and turns them into a single interrupt request. A receiver core sends one-cycle pulses to it: a character is waiting, the line has gone idle, a character was overrun, noise was seen, or a stop bit was missing. Each pulse sets a sticky flag. A status read and a data read from the host side clear the flags, in that order.

The 8-bit status word also carries two transmit-side bits. The transmitter supplies them, and this unit registers them. The interrupt line is a function of the flags and of three host control bits: a receive interrupt enable, a separate idle interrupt enable, and a wakeup bit that silences receive interrupts.

A flag is cleared only by a full two-step sequence. First a status read must see the flag set. Then a data register read must follow. Any number of cycles may pass between the two reads. A new event for that flag that lands before the data read cancels the pending clear, so the event is never lost.

Top module: `rxflag_unit`

## Requirements
- R1: Status word layout: bit 7 transmit-empty, bit 6 transmit-done, bit 5 receive-full, bit 4 line-idle, bit 3 overrun, bit 2 noise, bit 1 framing error, bit 0 constant 0.
- R2: While reset is asserted and on the first cycle after it, the status word reads 8'hC0 and the interrupt line is low.
- R3: An event pulse with the receiver enabled sets its flag, and the flag shows in the status word from the cycle after the pulse.
- R4: A status read with a flag set arms that flag. A later data read clears an armed flag, visible from the cycle after the data read. Other cycles may come between the two reads.
- R5: A data read does not clear a flag that no earlier status read saw set. This covers a status read made while the flag was still clear.
- R6: An event for a flag that arrives after that flag was armed disarms it. This includes an event in the same cycle as the clearing data read. The flag then stays set until a new status read and data read follow.
- R7: While the receiver enable is 0, event pulses set no flag.
- R8: The interrupt line is `!wake & ((rx_ie & (rx_full | overrun)) | (idle_ie & line_idle))`. It is combinational from the flags and the current control inputs.
- R9: Bits 7 and 6 show the transmit-empty and transmit-done inputs sampled on the previous clock edge. They reset to 1.
- R10: Bit 0 of the status word is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en_i | input | 1 | Receiver enable; 0 blocks flag setting |
| wake_i | input | 1 | Receiver wakeup mode; 1 masks the interrupt |
| rx_ie_i | input | 1 | Receive-full and overrun interrupt enable |
| idle_ie_i | input | 1 | Line-idle interrupt enable |
| ev_full_i | input | 1 | Pulse: character ready in data register |
| ev_idle_i | input | 1 | Pulse: idle line detected |
| ev_ovr_i | input | 1 | Pulse: overrun |
| ev_noise_i | input | 1 | Pulse: noise on a sampled bit |
| ev_frame_i | input | 1 | Pulse: framing error |
| stat_rd_i | input | 1 | Status register read strobe |
| data_rd_i | input | 1 | Data register read strobe |
| tx_empty_i | input | 1 | Transmit buffer empty, from transmitter |
| tx_done_i | input | 1 | Transmission complete, from transmitter |
| status_o | output | 8 | Status word |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench targets four cases:
- A data read with no status read before it. A design that clears on the data read alone drops flags here.
- A status read made while a flag was still clear, followed by the flag setting. A design that arms every flag on any status read clears this flag too early.
- An event arriving between the two reads, or in the same cycle as the data read. A design that keeps the stale arm state loses the fresh event.
- Wakeup mode with each enable combination. A design that only gates the idle term, or that ignores the idle enable, raises interrupts at the wrong time.

// File: rtl/rxflag_pkg.sv
package rxflag_pkg;

  localparam int NUM_RXF = 5;
  localparam int STAT_W  = 8;
  localparam int TX_W    = 2;

  // Flag index order; position in the status word is derived from it.
  typedef enum logic [2:0] {
    RXF_FULL  = 3'd0,
    RXF_IDLE  = 3'd1,
    RXF_OVR   = 3'd2,
    RXF_NOISE = 3'd3,
    RXF_FRAME = 3'd4
  } rxf_idx_e;

  // Status bit occupied by receive flag i: full at 5 down to framing at 1.
  function automatic int rxf_bit(input int i);
    return NUM_RXF - i;
  endfunction

  function automatic logic [STAT_W-1:0] pack_status(
    input logic [TX_W-1:0]    tx,    // {empty, done}
    input logic [NUM_RXF-1:0] rxf
  );
    logic [STAT_W-1:0] w;
    w = '0;
    w[STAT_W-1] = tx[1];
    w[STAT_W-2] = tx[0];
    for (int i = 0; i < NUM_RXF; i++) w[rxf_bit(i)] = rxf[i];
    w[0] = 1'b0;
    return w;
  endfunction

  function automatic logic irq_calc(
    input logic [NUM_RXF-1:0] rxf,
    input logic rx_ie,
    input logic idle_ie,
    input logic wake
  );
    logic data_term, idle_term;
    data_term = rx_ie & (rxf[RXF_FULL] | rxf[RXF_OVR]);
    idle_term = idle_ie & rxf[RXF_IDLE];
    return ~wake & (data_term | idle_term);
  endfunction

endpackage

// File: rtl/rxflag_cell.sv
module rxflag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_en,
  input  logic ev,
  input  logic stat_rd,
  input  logic data_rd,
  output logic flag_o,
  output logic armed_o
);
  logic flag_q, armed_q;
  logic ev_ok, clr_hit, arm_hit;

  assign ev_ok   = ev & rx_en;
  assign clr_hit = data_rd & armed_q;
  assign arm_hit = stat_rd & flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag_q <= ev_ok | (flag_q & ~clr_hit);
      if (ev_ok || clr_hit) armed_q <= 1'b0;
      else if (arm_hit)     armed_q <= 1'b1;
    end
  end

  assign flag_o  = flag_q;
  assign armed_o = armed_q;

  AST_ARM_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> flag_q); // R4
  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && rx_en) |=> flag_q); // R3
  AST_EVENT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && rx_en) |=> !armed_q); // R6
  AST_OFF_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !flag_q) |=> !flag_q); // R7
  AST_CLEAR_NEEDS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(data_rd && armed_q)) |=> flag_q); // R5

endmodule

// File: rtl/rxflag_bank.sv
module rxflag_bank
  import rxflag_pkg::*;
#(
  parameter int N = NUM_RXF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_en,
  input  logic [N-1:0] ev,
  input  logic         stat_rd,
  input  logic         data_rd,
  output logic [N-1:0] flags_o,
  output logic [N-1:0] armed_o
);
  for (genvar g = 0; g < N; g++) begin : g_cell
    rxflag_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .rx_en   (rx_en),
      .ev      (ev[g]),
      .stat_rd (stat_rd),
      .data_rd (data_rd),
      .flag_o  (flags_o[g]),
      .armed_o (armed_o[g])
    );
  end
endmodule

// File: rtl/rxflag_txhold.sv
module rxflag_txhold #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tx_i,
  output logic [W-1:0] tx_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_q <= '1;
    else        tx_q <= tx_i;
  end

  AST_TX_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (tx_q == $past(tx_i))); // R9
endmodule

// File: rtl/rxflag_irq.sv
module rxflag_irq
  import rxflag_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_RXF-1:0] flags,
  input  logic               rx_ie,
  input  logic               idle_ie,
  input  logic               wake,
  output logic               irq_o
);
  assign irq_o = irq_calc(flags, rx_ie, idle_ie, wake);

  AST_WAKE_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> !irq_o); // R8
  AST_NO_FLAG_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> !irq_o); // R8
endmodule

// File: rtl/rxflag_unit.sv
module rxflag_unit
  import rxflag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en_i,
  input  logic              wake_i,
  input  logic              rx_ie_i,
  input  logic              idle_ie_i,
  input  logic              ev_full_i,
  input  logic              ev_idle_i,
  input  logic              ev_ovr_i,
  input  logic              ev_noise_i,
  input  logic              ev_frame_i,
  input  logic              stat_rd_i,
  input  logic              data_rd_i,
  input  logic              tx_empty_i,
  input  logic              tx_done_i,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_o
);
  logic [NUM_RXF-1:0] ev_vec, flags, armed;
  logic [TX_W-1:0]    tx_q;

  always_comb begin
    ev_vec            = '0;
    ev_vec[RXF_FULL]  = ev_full_i;
    ev_vec[RXF_IDLE]  = ev_idle_i;
    ev_vec[RXF_OVR]   = ev_ovr_i;
    ev_vec[RXF_NOISE] = ev_noise_i;
    ev_vec[RXF_FRAME] = ev_frame_i;
  end

  rxflag_bank #(.N(NUM_RXF)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_en   (rx_en_i),
    .ev      (ev_vec),
    .stat_rd (stat_rd_i),
    .data_rd (data_rd_i),
    .flags_o (flags),
    .armed_o (armed)
  );

  rxflag_txhold #(.W(TX_W)) u_tx (
    .clk   (clk),
    .rst_n (rst_n),
    .tx_i  ({tx_empty_i, tx_done_i}),
    .tx_q  (tx_q)
  );

  rxflag_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .flags   (flags),
    .rx_ie   (rx_ie_i),
    .idle_ie (idle_ie_i),
    .wake    (wake_i),
    .irq_o   (irq_o)
  );

  assign status_o = pack_status(tx_q, flags);

  AST_ARM_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    ((armed & ~flags) == '0)); // R4
  AST_FULL_BIT_POS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_full_i && rx_en_i |=> status_o[5]); // R1
endmodule

// File: tb/tb_rxflag_unit.sv
module tb_rxflag_unit;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en_i = 1'b1, wake_i = 1'b0, rx_ie_i = 1'b0, idle_ie_i = 1'b0;
  logic ev_full_i = 1'b0, ev_idle_i = 1'b0, ev_ovr_i = 1'b0;
  logic ev_noise_i = 1'b0, ev_frame_i = 1'b0;
  logic stat_rd_i = 1'b0, data_rd_i = 1'b0;
  logic tx_empty_i = 1'b1, tx_done_i = 1'b1;
  logic [7:0] status_o;
  logic irq_o;

  always #(CLK_P/2) clk = ~clk;

  rxflag_unit dut (.*);

  int n_chk = 0, n_fail = 0;
  // Model: index 0 full, 1 idle, 2 overrun, 3 noise, 4 framing
  logic [4:0] mf = '0, ma = '0;
  logic       m_te = 1'b1, m_tc = 1'b1;

  // Next-cycle stimulus
  logic [4:0] nx_ev;
  logic nx_st, nx_dr, nx_en, nx_wk, nx_rie, nx_iie, nx_te, nx_tc;

  function automatic logic [7:0] exp_status();
    // R1 layout: 7 te, 6 tc, 5 full, 4 idle, 3 ovr, 2 noise, 1 frame, 0 zero
    return {m_te, m_tc, mf[0], mf[1], mf[2], mf[3], mf[4], 1'b0};
  endfunction

  function automatic logic exp_irq();
    if (wake_i) return 1'b0;
    return (rx_ie_i & (mf[0] | mf[2])) | (idle_ie_i & mf[1]);
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_nx();
    nx_ev = '0; nx_st = 0; nx_dr = 0; nx_en = 1; nx_wk = wake_i;
    nx_rie = rx_ie_i; nx_iie = idle_ie_i; nx_te = tx_empty_i; nx_tc = tx_done_i;
  endtask

  // Check the current cycle, then apply nx_* and advance the model.
  task automatic tick();
    @(negedge clk);
    chk(status_o, exp_status(), "R3 R4 R5 R6 R7 R9 status");
    chk({7'd0, status_o[0]}, 8'd0, "R10 bit0");
    chk({7'd0, irq_o}, {7'd0, exp_irq()}, "R8 irq");
    {ev_frame_i, ev_noise_i, ev_ovr_i, ev_idle_i, ev_full_i} = nx_ev;
    stat_rd_i = nx_st; data_rd_i = nx_dr; rx_en_i = nx_en; wake_i = nx_wk;
    rx_ie_i = nx_rie; idle_ie_i = nx_iie; tx_empty_i = nx_te; tx_done_i = nx_tc;
    for (int i = 0; i < 5; i++) begin
      logic ok, clr;
      ok  = nx_ev[i] & nx_en;
      clr = nx_dr & ma[i];
      if (ok || clr) ma[i] = 1'b0;
      else if (nx_st && mf[i]) ma[i] = 1'b1;
      mf[i] = ok | (mf[i] & ~clr);
    end
    m_te = nx_te; m_tc = nx_tc;
    idle_nx();
  endtask

  task automatic expect_stat(input logic [7:0] exp, input string req);
    @(posedge clk); #(CLK_P/4);
    chk(status_o, exp, req);
  endtask

  task automatic expect_irq(input logic exp, input string req);
    @(posedge clk); #(CLK_P/4);
    chk({7'd0, irq_o}, {7'd0, exp}, req);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int seed;
    seed = 32'h5EED_0042;
    void'($urandom(seed));
    idle_nx();
    #(CLK_P * 2 + 2);
    chk(status_o, 8'hC0, "R2 reset status");
    chk({7'd0, irq_o}, 8'd0, "R2 reset irq");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(status_o, 8'hC0, "R2 post-reset status");

    // R3: set receive-full
    nx_ev = 5'b00001; tick(); expect_stat(8'hE0, "R3 full set");
    // R5: data read without status read
    nx_dr = 1; tick(); expect_stat(8'hE0, "R5 data read alone");
    // R4: status read, gap, data read
    nx_st = 1; tick(); tick(); nx_dr = 1; tick(); expect_stat(8'hC0, "R4 clear sequence");
    // R5: stale status read seen while clear
    nx_st = 1; tick(); nx_ev = 5'b00100; tick(); nx_dr = 1; tick();
    expect_stat(8'hC8, "R5 stale status read");
    // R6: event between reads
    nx_st = 1; tick(); nx_ev = 5'b00100; tick(); nx_dr = 1; tick();
    expect_stat(8'hC8, "R6 event between reads");
    nx_st = 1; tick(); nx_dr = 1; tick(); expect_stat(8'hC0, "R4 reclear");
    // R6: event same cycle as data read
    nx_ev = 5'b01000; tick(); nx_st = 1; tick();
    nx_dr = 1; nx_ev = 5'b01000; tick(); expect_stat(8'hC4, "R6 same-cycle event");
    nx_st = 1; tick(); nx_dr = 1; tick(); expect_stat(8'hC0, "R4 noise clear");
    // R7: receiver off
    nx_en = 0; nx_ev = 5'b11111; tick(); expect_stat(8'hC0, "R7 receiver off");
    // R1 framing bit position
    nx_ev = 5'b10000; tick(); expect_stat(8'hC2, "R1 framing bit");
    // R8 interrupt behaviour
    nx_rie = 1; nx_ev = 5'b00001; tick(); expect_irq(1'b1, "R8 full irq");
    nx_wk = 1; tick(); expect_irq(1'b0, "R8 wake masks");
    nx_wk = 0; nx_rie = 0; nx_ev = 5'b00010; tick(); expect_irq(1'b0, "R8 idle no enable");
    nx_iie = 1; tick(); expect_irq(1'b1, "R8 idle enabled");
    // R9 transmit bits
    nx_te = 0; nx_tc = 1; tick(); expect_stat({2'b01, 6'b0} | (status_o & 8'h3E), "R9 tx empty low");

    // Constrained random
    for (int k = 0; k < 4000; k++) begin
      for (int i = 0; i < 5; i++) nx_ev[i] = ($urandom % 8) == 0;
      nx_st  = ($urandom % 4) == 0;
      nx_dr  = ($urandom % 4) == 0;
      nx_en  = ($urandom % 8) != 0;
      nx_wk  = ($urandom % 8) == 0;
      nx_rie = $urandom % 2;
      nx_iie = $urandom % 2;
      nx_te  = $urandom % 2;
      nx_tc  = $urandom % 2;
      tick();
    end
    idle_nx(); tick(); tick();
    finish_run();
  end
endmodule